// File: doc/BRIEF.md
# E3 LOS/AIS Defect Monitor

This block sits behind the clock-and-data recovery of an E3 receiver. It watches the recovered bit stream, one bit per cycle in which `bit_en` is high, and keeps two live defect flags. Loss of signal (LOS) comes from two sources. One is an internal detector that fires on a long run of zero bits. The other is a LOS indication from the line interface. A mode bit chooses whether the internal detector takes part or LOS follows the line interface alone.

The alarm indication signal (AIS) is judged once per frame. The frame start is marked by `frame_start`, which is high together with `bit_en` on the first bit of each frame. At each frame start the zero counts of the last two complete frames are added. AIS is declared when that total is small enough and cleared when it is not.

Each defect also has a change-of-state interrupt bit. These bits clear when read. Per-bit enables gate them onto one level interrupt. A small four-address register port gives access to the mode, status, interrupt and enable registers.

Top module: `e3_defect_mon`

## Requirements
- R1: After reset the mode register reads 0x08, and the status, interrupt status and interrupt enable registers read 0x00. `los`, `ais` and `irq` are low.
- R2: With internal LOS enabled (mode bit 3 = 1), LOS is declared after LOS_RUN consecutive zero bits and not after LOS_RUN-1. It shows on `los` and on status bit 1 two cycles after the last zero is accepted.
- R3: Internal LOS clears on the first received one bit.
- R4: With mode bit 3 = 0, the zero-run detector is disabled. Any number of zeros leaves LOS low while `liu_los` is low.
- R5: `liu_los` high sets LOS one cycle later in either mode. With internal LOS enabled, LOS is the OR of both sources.
- R6: At each frame start, the sum of the zero counts of the previous frame and of the frame just finished is compared with AIS_MAX. A sum of AIS_MAX or less sets AIS and a larger sum clears it. AIS shows on `ais` and on status bit 3, and changes only in the cycle after a frame start.
- R7: After reset AIS stays low until two complete frames have been counted. The first decision is made at the third frame start.
- R8: Each frame's zero count saturates at 2^ZCNT_W-1 and does not wrap.
- R9: Interrupt status bit 0 is set on any change of AIS, and bit 1 on any change of LOS, for both rising and falling edges. Bits 7:2 read 0.
- R10: Reading the interrupt status register (address 2) clears it. A change that occurs in the cycle of the read is kept, and shows on the next read.
- R11: `irq` is high whenever an interrupt status bit and the matching enable bit (address 3, bits 1:0) are both 1.
- R12: Register map:
  - address 0 is the mode register; only bit 3 is writable and the other bits read 0;
  - address 1 is status (read only);
  - address 2 is interrupt status;
  - address 3 is interrupt enable, with bits 1:0 writable.
  
  `reg_rdata` reflects `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | A received bit is valid this cycle |
| rx_bit | input | 1 | Received data bit |
| frame_start | input | 1 | First bit of a frame (qualified by bit_en) |
| liu_los | input | 1 | LOS indication from the line interface |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| los | output | 1 | LOS defect |
| ais | output | 1 | AIS defect |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with LOS_RUN = 32 and AIS_MAX = 7, the values the line standard calls for. This lets it check the 31-versus-32 zero boundary and the 7-versus-8 AIS boundary exactly. ZCNT_W is lowered to 5, so a frame of 38 zeros passes the 31 ceiling of the per-frame counter. A wrapping counter would then read 6 and falsely declare AIS, which brings the saturation rule within reach. Frames of 48 bits keep every AIS case to a few hundred cycles.

// File: rtl/e3_defect_mon.sv
module e3_defect_mon #(
  parameter int LOS_RUN = 32,
  parameter int AIS_MAX = 7,
  parameter int ZCNT_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       frame_start,
  input  logic       liu_los,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       los,
  output logic       ais,
  output logic       irq
);
  localparam int LW = $clog2(LOS_RUN + 1);
  localparam logic [LW-1:0] RUN_END = LW'(LOS_RUN);
  localparam logic [LW-1:0] RUN_LAST = LW'(LOS_RUN - 1);
  localparam logic [ZCNT_W:0] AIS_LIM = (ZCNT_W + 1)'(AIS_MAX);
  localparam logic [ZCNT_W-1:0] ZMAX = '1;
  localparam logic [1:0] A_MODE = 2'd0, A_STAT = 2'd1, A_INT = 2'd2, A_IEN = 2'd3;

  logic              los_en, int_los, los_r, ais_r, ais_n, los_n;
  logic [LW-1:0]     zrun;
  logic [ZCNT_W-1:0] cur_z, prev_z;
  logic [ZCNT_W:0]   total;
  logic [1:0]        seen, ist, ien, chg;

  wire zero_bit = bit_en & ~rx_bit;
  wire fs       = frame_start & bit_en;
  wire rd_clr   = reg_rd && reg_addr == A_INT;
  wire unused_ok = &{1'b0, reg_wdata[7:4], reg_wdata[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zrun    <= '0;
      int_los <= 1'b0;
    end else if (!los_en) begin
      zrun    <= '0;
      int_los <= 1'b0;
    end else if (bit_en) begin
      if (rx_bit) begin
        zrun    <= '0;
        int_los <= 1'b0;
      end else if (zrun != RUN_END) begin
        zrun <= zrun + 1'b1;
        if (zrun == RUN_LAST) int_los <= 1'b1;
      end
    end
  end

  assign total = {1'b0, prev_z} + {1'b0, cur_z};

  always_comb begin
    ais_n = ais_r;
    if (fs && seen == 2'd2) ais_n = (total <= AIS_LIM);
  end

  assign los_n = liu_los | (los_en & int_los);
  assign chg   = {los_n ^ los_r, ais_n ^ ais_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_z  <= '0;
      prev_z <= '0;
      seen   <= '0;
      ais_r  <= 1'b0;
      los_r  <= 1'b0;
      ist    <= '0;
    end else begin
      if (fs) begin
        prev_z <= cur_z;
        cur_z  <= zero_bit ? ZCNT_W'(1) : '0;
        if (seen != 2'd2) seen <= seen + 1'b1;
      end else if (zero_bit && cur_z != ZMAX) begin
        cur_z <= cur_z + 1'b1;
      end
      ais_r <= ais_n;
      los_r <= los_n;
      ist   <= (rd_clr ? 2'b00 : ist) | chg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los_en <= 1'b1;
      ien    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_MODE) los_en <= reg_wdata[3];
      if (reg_addr == A_IEN)  ien    <= reg_wdata[1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {4'b0, los_en, 3'b0};
      A_STAT:  reg_rdata = {4'b0, ais_r, 1'b0, los_r, 1'b0};
      A_INT:   reg_rdata = {6'b0, ist};
      default: reg_rdata = {6'b0, ien};
    endcase
  end

  assign los = los_r;
  assign ais = ais_r;
  assign irq = |(ist & ien);

  // R2
  los_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_los) |-> zrun == RUN_END);
  // R3
  los_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && rx_bit |=> !int_los);
  // R4
  liu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !los_en && !liu_los |=> !los);
  // R5
  los_liu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    liu_los |=> los);
  // R6
  ais_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start && bit_en) |-> $stable(ais));
  // R9
  ais_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ais != $past(ais) |-> ist[0]);
  // R9
  los_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    los != $past(los) |-> ist[1]);
  // R10
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && chg == 2'b00 |=> ist == 2'b00);
endmodule

// File: tb/e3_defect_mon_tb.sv
module e3_defect_mon_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, rx_bit = 1, frame_start = 0, liu_los = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic los, ais, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  e3_defect_mon #(.LOS_RUN(32), .AIS_MAX(7), .ZCNT_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .liu_los(liu_los), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .los(los), .ais(ais), .irq(irq));

  always @(negedge clk) begin
    if (reg_rd) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: act %h exp none", reg_rdata);
      end else begin
        it = sb.pop_front();
        if (reg_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: act %h exp %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic step; @(posedge clk); #1; endtask

  task automatic send(input logic b, input logic fs);
    bit_en = 1; rx_bit = b; frame_start = fs; step; bit_en = 0; frame_start = 0;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag; sb.push_back(it);
    reg_addr = a; reg_rd = 1; step; reg_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step; reg_wr = 0;
  endtask

  task automatic pin(input string tag, input logic act, input logic e);
    #1;
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: act %b exp %b", tag, act, e);
    end
  endtask

  task automatic frame(input int z);
    for (int i = 0; i < 48; i++) send(i < z ? 1'b0 : 1'b1, i == 0);
    step;
  endtask

  task automatic do_reset;
    rst_n = 0; step; step; rst_n = 1;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: act timeout exp completion");
    finish_up;
  end

  initial begin
    do_reset;
    rd(0, 8'h08, "R1 mode reset");
    rd(1, 8'h00, "R1 status reset");
    rd(2, 8'h00, "R1 int reset");
    rd(3, 8'h00, "R1 ien reset");
    pin("R1 los pin", los, 0);
    pin("R1 ais pin", ais, 0);
    pin("R1 irq pin", irq, 0);

    zeros(31); step;
    rd(1, 8'h00, "R2 31 zeros");
    zeros(1); step;
    rd(1, 8'h02, "R2 32 zeros");
    pin("R2 los pin", los, 1);
    rd(2, 8'h02, "R9 los rise");
    rd(2, 8'h00, "R10 cleared");
    send(1'b1, 1'b0); step;
    rd(1, 8'h00, "R3 first one");
    rd(2, 8'h02, "R9 los fall");

    wr(0, 8'h00);
    rd(0, 8'h00, "R12 mode write");
    zeros(40); step;
    rd(1, 8'h00, "R4 liu only");
    liu_los = 1; step;
    rd(1, 8'h02, "R5 liu los");
    liu_los = 0; wr(0, 8'h08); step;
    rd(1, 8'h00, "R5 liu clear");
    rd(2, 8'h02, "R9 liu edges");
    liu_los = 1; step;
    rd(1, 8'h02, "R5 or internal");
    rd(2, 8'h02, "R9 clear");
    liu_los = 0;
    rd(2, 8'h00, "R10 read in change cycle");
    rd(2, 8'h02, "R10 change kept");
    liu_los = 1; step;
    wr(3, 8'h02);
    pin("R11 irq enabled", irq, 1);
    wr(3, 8'h01);
    pin("R11 irq masked", irq, 0);
    rd(3, 8'h01, "R12 ien read");
    rd(2, 8'h02, "R9 clear before ais");
    liu_los = 0;

    do_reset;
    frame(0); rd(1, 8'h00, "R7 one frame");
    frame(0); rd(1, 8'h00, "R7 two frames");
    frame(0); rd(1, 8'h08, "R6 ais declared");
    pin("R6 ais pin", ais, 1);
    rd(2, 8'h01, "R9 ais rise");
    frame(4); rd(1, 8'h08, "R6 total 0");
    frame(3); rd(1, 8'h08, "R6 total 4");
    frame(5); rd(1, 8'h08, "R6 total 7");
    frame(0); rd(1, 8'h00, "R6 total 8");
    frame(38); rd(1, 8'h08, "R6 total 5");
    frame(0); rd(1, 8'h00, "R8 saturated");
    frame(0); rd(1, 8'h00, "R8 saturated prev");
    rd(2, 8'h03, "R9 both changed");

    step; step;
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: act %0d pending exp 0", sb.size());
    end
    finish_up;
  end
endmodule